// File: doc/BRIEF.md
# Serial Program/Verify Target Port

This block is the device-side end of a two-wire serial programming link for a small flash microcontroller model. A host toggles a serial clock and a bidirectional data line. The block decodes 6-bit commands and exchanges 14-bit data frames. It keeps a program counter and a word-wide program memory, both held inside the block. While the mode-enable input is high, the block owns the device: the rest of the chip is held in reset and the program memory can be loaded, written, read back and stepped through.

All logic runs on the system clock. The serial clock and data input are treated as slow level signals that the block samples with that clock. The block finds rising and falling serial-clock edges by comparing each sample with the one before it. A command is six falling edges long, with the least significant bit first. Load and Read are each followed by a 16-clock data segment. That segment has a start cycle, fourteen data cycles and a stop cycle. On a Read, the block turns the data line around on fixed rising edges.

Top module: `sprog_port`

## Requirements
- R1: `dev_hold_rst` is low after reset. It goes high on the system clock after `prog_en` rises and low on the system clock after `prog_en` falls.
- R2: Every entry into program mode (a rise of `prog_en`) sets the program counter to 0x3FF.
- R3: A command is six bits taken from `sdat_in` on six falling serial-clock edges, least significant bit first. The codes are Load 0x02, Read 0x04, Increment 0x06, Begin Programming 0x08 and End Programming 0x0E.
- R4: A Load is followed by 16 serial clocks. The bits taken on falling edges 2 to 15 form a 14-bit word, least significant bit first, and bits 11:0 of that word go into the data latch. The bits on falling edges 1 and 16 (start and stop), and word bits 13:12, have no effect.
- R5: Begin Programming writes the data latch into the memory word at the program counter.
- R6: A Read is followed by 16 serial clocks. `sdat_oe` goes high at rising edge 2 and low at rising edge 16. From rising edge k (k = 2 to 15), `sdat_out` carries bit k-2 of the word at the program counter, with bits 13:12 returned as zero.
- R7: Increment adds one to the program counter, and 0x3FF wraps to 0x000. No other command moves the counter.
- R8: End Programming and every code not listed in R3 leave the program counter, the data latch and the memory unchanged.
- R9: When `prog_en` falls, including in the middle of a data segment, the block goes idle and releases the data line. The next entry starts a fresh command.
- R10: `sdat_oe` is high only during the driven part of a Read data segment in program mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Program-mode enable (stands in for high-voltage entry) |
| sclk | input | 1 | Serial clock from the host |
| sdat_in | input | 1 | Serial data from the pin |
| sdat_out | output | 1 | Serial data driven toward the pin |
| sdat_oe | output | 1 | Output enable for the data pin driver |
| dev_hold_rst | output | 1 | Holds the rest of the device in reset while in program mode |

## Verification
Forty-eight consecutive addresses are written with words from an arithmetic pattern, and every one is read back after a fresh mode entry. This exposes any reversed bit order, stuck bit or wrong address step. A word with bits 13:12 and the start/stop bits set is written at the entry address. This separates correct framing from data that is off by one cycle, and it confirms the 0x3FF reset value and the wrap to zero. A burst of End Programming and unknown codes between a Load and a Begin Programming must move neither the counter nor the latch. A Read cut short by dropping the mode checks that the data line is released.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] CMD_LOAD  = 6'h02;
    localparam logic [CMD_W-1:0] CMD_READ  = 6'h04;
    localparam logic [CMD_W-1:0] CMD_INC   = 6'h06;
    localparam logic [CMD_W-1:0] CMD_BEGIN = 6'h08;
    localparam logic [CMD_W-1:0] CMD_END   = 6'h0E;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } port_st_e;

endpackage

// File: rtl/sprog_edge.sv
module sprog_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/sprog_mem.sv
module sprog_mem #(
    parameter int AW = 10,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells_q[addr] <= wdata;
    end

    assign rdata = cells_q[addr];
endmodule

// File: rtl/sprog_port.sv
module sprog_port
    import sprog_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int WORD_W  = 12,
    parameter int FRAME_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic sclk,
    input  logic sdat_in,
    output logic sdat_out,
    output logic sdat_oe,
    output logic dev_hold_rst
);
    localparam int SEG_LEN = FRAME_W + 2;
    localparam int CNT_W   = $clog2(SEG_LEN);
    localparam int CC_W    = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] STOP_CYC  = CNT_W'(FRAME_W + 1);
    localparam logic [CC_W-1:0]  LAST_CMD  = CC_W'(CMD_W - 1);

    typedef struct packed {
        logic               mode;
        port_st_e           st;
        logic [CMD_W-1:0]   cmd;
        logic [CC_W-1:0]    ccnt;
        logic [CNT_W-1:0]   fcnt;
        logic [CNT_W-1:0]   rcnt;
        logic               is_rd;
        logic [FRAME_W-1:0] din;
        logic [FRAME_W-1:0] dout_sh;
        logic [WORD_W-1:0]  latch;
        logic [PC_W-1:0]    pc;
        logic               oe;
        logic               dout;
    } port_s;

    port_s s_d, s_q;
    logic  rise_w, fall_w;
    logic  we_d;
    logic [WORD_W-1:0] rdata_w;
    logic [CMD_W-1:0]  cmd_full;

    sprog_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sclk),
        .rise (rise_w),
        .fall (fall_w)
    );

    sprog_mem #(.AW(PC_W), .DW(WORD_W)) u_mem (
        .clk  (clk),
        .we   (we_d),
        .addr (s_q.pc),
        .wdata(s_q.latch),
        .rdata(rdata_w)
    );

    assign cmd_full = {sdat_in, s_q.cmd[CMD_W-1:1]};

    always_comb begin
        s_d  = s_q;
        we_d = 1'b0;
        if (!prog_en) begin
            s_d.mode = 1'b0;
            s_d.st   = ST_OFF;
            s_d.oe   = 1'b0;
            s_d.dout = 1'b0;
        end else if (!s_q.mode) begin
            s_d.mode = 1'b1;
            s_d.st   = ST_CMD;
            s_d.pc   = '1;
            s_d.ccnt = '0;
            s_d.oe   = 1'b0;
            s_d.dout = 1'b0;
        end else begin
            case (s_q.st)
                ST_CMD: begin
                    if (fall_w) begin
                        s_d.cmd = cmd_full;
                        if (s_q.ccnt == LAST_CMD) begin
                            s_d.ccnt = '0;
                            case (cmd_full)
                                CMD_LOAD: begin
                                    s_d.st    = ST_DATA;
                                    s_d.is_rd = 1'b0;
                                    s_d.fcnt  = '0;
                                    s_d.rcnt  = '0;
                                end
                                CMD_READ: begin
                                    s_d.st      = ST_DATA;
                                    s_d.is_rd   = 1'b1;
                                    s_d.fcnt    = '0;
                                    s_d.rcnt    = '0;
                                    s_d.dout_sh = FRAME_W'(rdata_w);
                                end
                                CMD_INC:   s_d.pc = s_q.pc + 1'b1;
                                CMD_BEGIN: we_d   = 1'b1;
                                default: ;
                            endcase
                        end else begin
                            s_d.ccnt = s_q.ccnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (rise_w) begin
                        if (s_q.is_rd) begin
                            if (s_q.rcnt != '0 && s_q.rcnt <= LAST_BIT) begin
                                s_d.oe      = 1'b1;
                                s_d.dout    = s_q.dout_sh[0];
                                s_d.dout_sh = s_q.dout_sh >> 1;
                            end else if (s_q.rcnt == STOP_CYC) begin
                                s_d.oe   = 1'b0;
                                s_d.dout = 1'b0;
                            end
                        end
                        s_d.rcnt = s_q.rcnt + 1'b1;
                    end
                    if (fall_w) begin
                        if (!s_q.is_rd && s_q.fcnt != '0 && s_q.fcnt <= LAST_BIT)
                            s_d.din = {sdat_in, s_q.din[FRAME_W-1:1]};
                        if (s_q.fcnt == STOP_CYC) begin
                            s_d.st   = ST_CMD;
                            s_d.ccnt = '0;
                            s_d.oe   = 1'b0;
                            if (!s_q.is_rd) s_d.latch = s_q.din[WORD_W-1:0];
                        end
                        s_d.fcnt = s_q.fcnt + 1'b1;
                    end
                end
                default: begin
                    s_d.st   = ST_CMD;
                    s_d.ccnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdat_out     = s_q.dout;
    assign sdat_oe      = s_q.oe;
    assign dev_hold_rst = s_q.mode;

    // R10: the driver is never on outside program mode
    assert_oe_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.mode |-> !sdat_oe);

    // R6: the driver turns on only in response to a serial-clock rise
    assert_oe_on_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdat_oe) |-> $past(rise_w));

    // R2: every mode entry loads the top address
    assert_entry_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode) |-> s_q.pc == {PC_W{1'b1}});

    // R7: inside the mode the counter only ever steps by one
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode && $past(s_q.mode) && s_q.pc != $past(s_q.pc))
            |-> s_q.pc == $past(s_q.pc) + 1'b1);

    // R5: memory is written only on the last falling edge of a command
    assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_d |-> (fall_w && s_q.st == ST_CMD));
endmodule

// File: tb/tb_sprog_port.sv
`timescale 1ns/1ps
module tb_sprog_port;
    localparam int NW = 48;
    localparam int WDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic sclk = 1'b0;
    logic sdat_in = 1'b0;
    logic sdat_out, sdat_oe, dev_hold_rst;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sprog_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_en     (prog_en),
        .sclk        (sclk),
        .sdat_in     (sdat_in),
        .sdat_out    (sdat_out),
        .sdat_oe     (sdat_oe),
        .dev_hold_rst(dev_hold_rst)
    );

    function automatic logic [11:0] pat(input int i);
        return 12'((i * 2515 + 1445) ^ (i << 5));
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic half();
        repeat (2) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        sdat_in = b;
        sclk = 1'b1;
        half();
        sclk = 1'b0;
        half();
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) clk_bit(c[i]);
    endtask

    task automatic load(input logic [13:0] w, input logic frame_bit);
        send_cmd(6'h02);
        clk_bit(frame_bit);
        for (int i = 0; i < 14; i++) clk_bit(w[i]);
        clk_bit(frame_bit);
    endtask

    // R6: read one segment, check turn-around edges and returned word
    task automatic read_chk(input logic [11:0] exp, input string req);
        logic [13:0] got;
        bit oe_ok;
        got = '0;
        oe_ok = 1'b1;
        send_cmd(6'h04);
        for (int k = 1; k <= 16; k++) begin
            sdat_in = 1'b1;
            sclk = 1'b1;
            half();
            if (k == 1 || k == 16) begin
                if (sdat_oe !== 1'b0) oe_ok = 1'b0;
            end else begin
                if (sdat_oe !== 1'b1) oe_ok = 1'b0;
                got[k-2] = sdat_out;
            end
            sclk = 1'b0;
            half();
        end
        chk(oe_ok, "R6 oe window", int'(oe_ok), 1);
        chk(got == {2'b00, exp}, req, int'(got), int'({2'b00, exp}));
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog got=0x0 exp=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dev_hold_rst === 1'b0, "R1 reset hold", int'(dev_hold_rst), 0);
        chk(sdat_oe === 1'b0, "R10 reset oe", int'(sdat_oe), 0);
        rst_n = 1'b1;
        half();
        chk(dev_hold_rst === 1'b0, "R1 idle hold", int'(dev_hold_rst), 0);

        prog_en = 1'b1;
        half();
        chk(dev_hold_rst === 1'b1, "R1 mode hold", int'(dev_hold_rst), 1);
        chk(sdat_oe === 1'b0, "R10 oe after entry", int'(sdat_oe), 0);

        // R4: top bits and start/stop set must not reach the latch
        load({2'b11, 12'hC3A}, 1'b1);
        send_cmd(6'h08);
        read_chk(12'hC3A, "R4 R5 entry word");

        // R7: wrap from 0x3FF to 0, then sweep NW addresses
        send_cmd(6'h06);
        for (int i = 0; i < NW; i++) begin
            load({2'b00, pat(i)}, 1'b0);
            send_cmd(6'h08);
            send_cmd(6'h06);
        end

        // R8: End and unknown codes touch neither pc, latch nor memory
        load({2'b00, 12'h5A5}, 1'b0);
        send_cmd(6'h08);
        load({2'b00, 12'h3C3}, 1'b0);
        send_cmd(6'h0E);
        send_cmd(6'h3F);
        send_cmd(6'h01);
        send_cmd(6'h00);
        read_chk(12'h5A5, "R8 memory and pc kept");
        send_cmd(6'h08);
        read_chk(12'h3C3, "R8 latch kept");

        // R9: abort in mid read
        send_cmd(6'h04);
        for (int k = 0; k < 5; k++) clk_bit(1'b0);
        chk(sdat_oe === 1'b1, "R6 oe mid read", int'(sdat_oe), 1);
        prog_en = 1'b0;
        half();
        chk(sdat_oe === 1'b0, "R9 oe released", int'(sdat_oe), 0);
        chk(dev_hold_rst === 1'b0, "R1 hold released", int'(dev_hold_rst), 0);
        for (int k = 0; k < 3; k++) clk_bit(1'b1);
        chk(sdat_oe === 1'b0, "R10 idle clocks", int'(sdat_oe), 0);

        // R2: re-entry points at 0x3FF; R3 R7: readback sweep
        prog_en = 1'b1;
        half();
        read_chk(12'hC3A, "R2 entry address");
        send_cmd(6'h06);
        for (int i = 0; i < NW; i++) begin
            read_chk(pat(i), $sformatf("R3 R7 readback addr %0d", i));
            send_cmd(6'h06);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule